// File: doc/BRIEF.md
# Two-Bit Branch Direction and Target Predictor

This block is a direct-mapped table that guesses, at fetch time, whether a conditional branch will be taken and where it will go. The fetch address is split into an index, taken from the low address bits above the instruction alignment, and a tag, which is every bit above the index. Each table slot holds a valid flag, the stored tag, a two-bit hysteresis state and the full branch target. A lookup is combinational. It reports a hit when the slot is valid and its tag matches. On a hit it also reports the predicted direction and the stored target.

When a branch resolves, the pipeline presents the branch address, the real outcome and the real target on the update port. On a hit, the slot's state moves one step toward the outcome and saturates at either end. The stored target is replaced only when the branch was taken. On a miss, the slot is taken over: it gets the new tag and the new target, and it starts in the weak state that agrees with the outcome. With the two-bit state, one odd outcome, such as a loop exit, does not turn a strong prediction around.

Top module: `bht_predictor`

## Requirements
- R1: After a synchronous reset, every lookup misses until an update allocates its slot.
- R2: A lookup that misses drives `lk_taken` = 0 and `lk_target` = 0.
- R3: The slot index is address bits [ALIGN_W+IDX_W-1:ALIGN_W] and the tag is the bits above it. A lookup with the same index but a different tag misses. An update with such an address replaces the slot, after which the former owner misses.
- R4: An update that misses writes the tag and the target. It sets the state to weak taken (2'b10) if the branch was taken, or weak not-taken (2'b01) if it was not.
- R5: The state encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken, and `lk_taken` is state bit 1 on a hit. An update that hits moves the state up by one step if the branch was taken and down by one step if it was not, saturating at 11 and 00.
- R6: From a strong state, the predicted direction flips only after two consecutive updates that disagree with it.
- R7: An update that hits replaces the stored target only when the branch was taken. A not-taken update keeps the old target.
- R8: A lookup in the same cycle as an update to the same slot returns the contents from before that update.
- R9: While `up_en` is 0, the table contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears every valid flag |
| lk_addr | input | ADDR_W | Fetch address to look up |
| lk_hit | output | ADDR_W>0 ? 1 : 1 | Slot is valid and its tag matches |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | ADDR_W | Predicted target on a hit, zero on a miss |
| up_en | input | 1 | Resolved branch present this cycle |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
A slot with a wrong state shows up at the ports as a wrong `lk_taken`, but only at the next lookup of that address. The error can also stay hidden for a while: a state that is off by one step, such as 10 instead of 11, gives the same prediction. It becomes visible only after the next not-taken update, when the direction flips one outcome too early. For this reason, the bench walks each slot through full up-and-down sequences and checks the direction after every step. A wrong tag or a wrong valid flag appears at once as a wrong `lk_hit`. A target that was written at the wrong time appears as a wrong `lk_target` on the next lookup. That is why lookups follow each not-taken update and each update that replaces a slot.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef enum logic [1:0] {
    HS_STRONG_NT = 2'b00,
    HS_WEAK_NT   = 2'b01,
    HS_WEAK_T    = 2'b10,
    HS_STRONG_T  = 2'b11
  } hyst_t;
endpackage

// File: rtl/bht_addr_split.sv
module bht_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2,
  localparam int TAG_W  = ADDR_W - IDX_W - ALIGN_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  assign idx = addr[ALIGN_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/bht_hyst_next.sv
module bht_hyst_next
  import bht_pkg::*;
(
  input  logic  hit,
  input  hyst_t cur,
  input  logic  taken,
  output hyst_t nxt
);
  always_comb begin
    if (!hit) begin
      nxt = taken ? HS_WEAK_T : HS_WEAK_NT;
    end else if (taken) begin
      nxt = (cur == HS_STRONG_T) ? HS_STRONG_T : hyst_t'(cur + 2'd1);
    end else begin
      nxt = (cur == HS_STRONG_NT) ? HS_STRONG_NT : hyst_t'(cur - 2'd1);
    end
  end

  // R6: from a strong state, one disagreeing outcome keeps the direction
  always_comb begin
    if (hit && (cur[1] == cur[0]) && (taken != cur[1])) begin
      a_r6_strong_holds: assert (nxt[1] == cur[1]);
    end
  end
endmodule

// File: rtl/bht_store.sv
module bht_store
  import bht_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 26,
  parameter int TGT_W  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_valid,
  output logic [TAG_W-1:0] ra_tag,
  output hyst_t            ra_state,
  output logic [TGT_W-1:0] ra_target,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output hyst_t            rb_state,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  hyst_t            w_state,
  input  logic             w_target_en,
  input  logic [TGT_W-1:0] w_target
);
  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  hyst_t            st_mem  [DEPTH];
  logic [TGT_W-1:0] tgt_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (we) begin
      valid_q[w_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx] <= w_tag;
      st_mem[w_idx]  <= w_state;
      if (w_target_en) begin
        tgt_mem[w_idx] <= w_target;
      end
    end
  end

  assign ra_valid  = valid_q[ra_idx];
  assign ra_tag    = tag_mem[ra_idx];
  assign ra_state  = st_mem[ra_idx];
  assign ra_target = tgt_mem[ra_idx];
  assign rb_valid  = valid_q[rb_idx];
  assign rb_tag    = tag_mem[rb_idx];
  assign rb_state  = st_mem[rb_idx];

  logic w_owner_match;
  assign w_owner_match = valid_q[w_idx] && (tag_mem[w_idx] == w_tag);

  // R4: an allocation leaves the slot in a weak state
  a_r4_alloc_weak: assert property (@(posedge clk) disable iff (rst)
    (we && !w_owner_match) |=>
      (st_mem[$past(w_idx)] == HS_WEAK_NT || st_mem[$past(w_idx)] == HS_WEAK_T));

  // R5: a taken update on an owned slot moves the state by at most one step up
  a_r5_step_up: assert property (@(posedge clk) disable iff (rst)
    (we && w_owner_match && w_target_en) |=>
      ({1'b0, st_mem[$past(w_idx)]} == {1'b0, $past(st_mem[w_idx])} ||
       {1'b0, st_mem[$past(w_idx)]} == {1'b0, $past(st_mem[w_idx])} + 3'd1));

  // R9: no write, no change of valid flags
  a_r9_no_write_stable: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(valid_q));
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 16,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  bht_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_lk_split (
    .addr(lk_addr), .idx(lk_idx), .tag(lk_tag));
  bht_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_up_split (
    .addr(up_addr), .idx(up_idx), .tag(up_tag));

  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag;
  hyst_t             a_state, b_state, w_state;
  logic [ADDR_W-1:0] a_target;
  logic              up_hit;

  bht_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .TGT_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .ra_idx(lk_idx), .ra_valid(a_valid), .ra_tag(a_tag), .ra_state(a_state),
    .ra_target(a_target),
    .rb_idx(up_idx), .rb_valid(b_valid), .rb_tag(b_tag), .rb_state(b_state),
    .we(up_en), .w_idx(up_idx), .w_tag(up_tag), .w_state(w_state),
    .w_target_en(!up_hit || up_taken), .w_target(up_target));

  assign up_hit = b_valid && (b_tag == up_tag);

  bht_hyst_next u_next (
    .hit(up_hit), .cur(b_state), .taken(up_taken), .nxt(w_state));

  assign lk_hit    = a_valid && (a_tag == lk_tag);
  assign lk_taken  = lk_hit && a_state[1];
  assign lk_target = lk_hit ? a_target : '0;

  // R1: the cycle after reset, nothing hits
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  // R2: a miss predicts not-taken with a zero target
  a_r2_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (!lk_taken && lk_target == '0));
endmodule

// File: tb/bht_predictor_tb.sv
module bht_predictor_tb;
  localparam int AW = 32;
  localparam logic [31:0] A  = 32'h0000_1004; // index 1
  localparam logic [31:0] B  = 32'h0004_1004; // index 1, other tag
  localparam logic [31:0] C  = 32'h0000_1008; // index 2

  typedef struct packed {
    logic        up_en;
    logic [31:0] up_addr;
    logic        up_tk;
    logic [31:0] up_tgt;
    logic [31:0] lk_addr;
    logic        e_hit;
    logic        e_tk;
    logic [31:0] e_tgt;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0, 1'b0, 32'h0,      A, 1'b0, 1'b0, 32'h0,    4'd2}, // R2 miss
    '{1'b1, A, 1'b1, 32'h2000,       A, 1'b0, 1'b0, 32'h0,    4'd8}, // R8 old view
    '{1'b0, 32'h0, 1'b0, 32'h0,      A, 1'b1, 1'b1, 32'h2000, 4'd4}, // R4 weak taken
    '{1'b1, A, 1'b1, 32'h2000,       A, 1'b1, 1'b1, 32'h2000, 4'd5}, // R5 ->11
    '{1'b1, A, 1'b0, 32'h9990,       A, 1'b1, 1'b1, 32'h2000, 4'd6}, // R6 11->10
    '{1'b1, A, 1'b0, 32'h9990,       A, 1'b1, 1'b1, 32'h2000, 4'd7}, // R7 10->01 keep tgt
    '{1'b0, 32'h0, 1'b0, 32'h0,      A, 1'b1, 1'b0, 32'h2000, 4'd6}, // R6 flipped
    '{1'b1, A, 1'b1, 32'h3000,       A, 1'b1, 1'b0, 32'h2000, 4'd5}, // R5 01->10
    '{1'b0, 32'h0, 1'b0, 32'h0,      A, 1'b1, 1'b1, 32'h3000, 4'd7}, // R7 taken writes tgt
    '{1'b0, 32'h0, 1'b0, 32'h0,      B, 1'b0, 1'b0, 32'h0,    4'd3}, // R3 tag mismatch
    '{1'b1, B, 1'b0, 32'h0500,       A, 1'b1, 1'b1, 32'h3000, 4'd8}, // R8 A still old
    '{1'b0, 32'h0, 1'b0, 32'h0,      B, 1'b1, 1'b0, 32'h0500, 4'd4}, // R4 weak nt
    '{1'b0, 32'h0, 1'b0, 32'h0,      A, 1'b0, 1'b0, 32'h0,    4'd3}, // R3 replaced
    '{1'b1, B, 1'b0, 32'h0700,       B, 1'b1, 1'b0, 32'h0500, 4'd5}, // R5 01->00
    '{1'b1, B, 1'b1, 32'h0600,       B, 1'b1, 1'b0, 32'h0500, 4'd5}, // R5 00->01
    '{1'b0, 32'h0, 1'b0, 32'h0,      B, 1'b1, 1'b0, 32'h0600, 4'd6}, // R6 one taken not enough
    '{1'b1, C, 1'b1, 32'h0800,       B, 1'b1, 1'b0, 32'h0600, 4'd3}, // R3 other index
    '{1'b0, 32'h0, 1'b0, 32'h0,      C, 1'b1, 1'b1, 32'h0800, 4'd4}  // R4 C allocated
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] lk_addr, up_addr, up_target, lk_target;
  logic          lk_hit, lk_taken, up_en, up_taken;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bht_predictor u_dut (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_taken(lk_taken), .lk_target(lk_target), .up_en(up_en),
    .up_addr(up_addr), .up_taken(up_taken), .up_target(up_target));

  task automatic check(input int req, input logic hit, input logic tk,
                       input logic [31:0] tgt);
    checks++;
    if (lk_hit !== hit || lk_taken !== tk || lk_target !== tgt) begin
      errors++;
      $display("FAIL R%0d: got hit=%0b tk=%0b tgt=%h expected hit=%0b tk=%0b tgt=%h",
               req, lk_hit, lk_taken, lk_target, hit, tk, tgt);
    end
  endtask

  initial begin
    rst = 1'b1; up_en = 1'b0; up_addr = '0; up_taken = 1'b0;
    up_target = '0; lk_addr = A;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check(1, 1'b0, 1'b0, 32'h0); // R1 reset state
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      up_en = VECS[i].up_en; up_addr = VECS[i].up_addr;
      up_taken = VECS[i].up_tk; up_target = VECS[i].up_tgt;
      lk_addr = VECS[i].lk_addr;
      #1 check(int'(VECS[i].req), VECS[i].e_hit, VECS[i].e_tk, VECS[i].e_tgt);
    end
    // R9: update fields present but up_en low leaves slot B unchanged
    @(negedge clk);
    up_en = 1'b0; up_addr = B; up_taken = 1'b1; up_target = 32'hdead_0000;
    lk_addr = B;
    @(negedge clk);
    @(negedge clk);
    #1 check(9, 1'b1, 1'b0, 32'h0600);
    up_addr = A; up_taken = 1'b1;
    @(negedge clk);
    lk_addr = A;
    #1 check(9, 1'b0, 1'b0, 32'h0); // R9 A not allocated
    // R5 saturation at strong taken, via C: 10 -> 11 -> 11, then one nt keeps taken
    up_en = 1'b1; up_addr = C; up_taken = 1'b1; up_target = 32'h0800;
    @(negedge clk); @(negedge clk);
    up_taken = 1'b0;
    @(negedge clk);
    up_en = 1'b0; lk_addr = C;
    #1 check(5, 1'b1, 1'b1, 32'h0800); // R5 saturated, 11->10 still taken
    // R1: mid-run reset empties the table
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    lk_addr = B;
    #1 check(1, 1'b0, 1'b0, 32'h0);
    lk_addr = C;
    #1 check(1, 1'b0, 1'b0, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule